// File: doc/BRIEF.md
# Compressed Decode Mode Tracker

This block follows an instruction stream that mixes ordinary 32-bit instructions with compressed halfwords and tells the decoder, one instruction at a time, how the instruction in front of it is to be read. It keeps a small state register holding one of four modes. Standard mode reads full-width instructions. The 10-bit payload mode applies to a halfword whose major opcode selects it. The 16-bit compressed mode reads whole halfwords. The pending mode reads exactly one standard instruction and then drops back into 16-bit mode.

Each presented instruction supplies its major opcode and the halfword whose two end bits steer the mode. The block reports three things. The first is the mode that applies to the presented instruction. The second is a flag marking the immediate-form compressed instruction. The third is the mode that will apply to the following instruction. The state moves only when the decoder accepts an instruction through a valid/ready handshake. A flush or reset returns it to standard mode. Expanding compressed instructions and aligning lengths are done elsewhere.

Mode codes on every mode port: standard = 2'b00, 10-bit = 2'b01, 16-bit = 2'b10, pending = 2'b11. Bit 0 of the halfword is its least significant bit and bit 15 (the top bit) its most significant.

Top module: `cdm_mode_fsm`

## Requirements
- R1: A synchronous active-low reset, or `flush` high at a clock edge, leaves the held mode at standard (2'b00) after that edge; `flush` wins over an accepted instruction in the same cycle.
- R2: The held mode changes only at an edge where `in_valid` and `in_ready` are both high; otherwise `cur_mode` for the same inputs is unchanged on the next cycle.
- R3: With standard held, an instruction whose major opcode is 0 or 1 is reported on `cur_mode` as 10-bit (2'b01) in the same cycle; any other major opcode is reported as standard and keeps standard as the next mode.
- R4: In 10-bit mode, an accepted halfword with bit 15 set makes the next mode 16-bit (2'b10).
- R5: In 10-bit mode, an accepted halfword with bit 15 clear makes the next mode standard.
- R6: In 16-bit mode, a valid halfword with bit 15 and bit 0 both set raises `imm_form` in the same cycle, and the next mode stays 16-bit.
- R7: In 16-bit mode, a halfword with bit 15 set and bit 0 clear keeps 16-bit mode and leaves `imm_form` low.
- R8: In 16-bit mode, a halfword with bit 15 and bit 0 both clear makes the next mode standard.
- R9: In 16-bit mode, a halfword with bit 15 clear and bit 0 set makes the next mode pending (2'b11).
- R10: In pending mode, the next accepted instruction is reported as pending whatever its opcode and bits, and after it the mode is 16-bit.
- R11: `next_mode` always equals the held mode after the coming edge (flush, accept or hold), and `imm_form` is high only when `in_valid` is high and `cur_mode` is 16-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Pipeline flush; forces standard mode |
| in_valid | input | 1 | Instruction presented |
| in_ready | input | 1 | Decoder accepts the presented instruction |
| in_major | input | MAJOR_W (6) | Major opcode of the presented instruction |
| in_hword | input | HW_W (16) | Halfword carrying the mode-steering end bits |
| cur_mode | output | 2 | Mode applying to the presented instruction |
| imm_form | output | 1 | Immediate-form compressed instruction |
| next_mode | output | 2 | Mode applying to the following instruction |

## Verification
`cur_mode`, `imm_form` and `next_mode` are combinational from the held mode and the present inputs, so they are due in the same cycle the inputs are applied. The held mode moves at the edge that accepts an instruction, so a transition is visible on `cur_mode` one cycle after that edge. The bench applies inputs just after a rising edge and compares all three outputs with its model at the following falling edge. It then advances the model at the rising edge, so every check falls in the cycle where the result is due and no check depends on how processes are ordered at an edge.

// File: rtl/cdm_pkg.sv
// Shared types for the compressed decode mode tracker.
// Assumes: mode codes are visible on ports as plain 2-bit vectors.
package cdm_pkg;

    typedef enum logic [1:0] {
        MODE_STD  = 2'b00,
        MODE_C10  = 2'b01,
        MODE_C16  = 2'b10,
        MODE_PEND = 2'b11
    } cdm_mode_e;

endpackage

// File: rtl/cdm_opc_match.sv
// Flags a major opcode that opens a 10-bit compressed halfword.
// Assumes: OPC_LIST packs NUM_OPC codes of MAJOR_W bits, entry 0 lowest.
module cdm_opc_match #(
    parameter int MAJOR_W = 6,
    parameter int NUM_OPC = 2,
    parameter logic [NUM_OPC*MAJOR_W-1:0] OPC_LIST = {6'd1, 6'd0}
) (
    input  logic [MAJOR_W-1:0] major,
    output logic               hit
);

    logic [NUM_OPC-1:0] hit_vec;

    // one comparator per listed opcode
    for (genvar i = 0; i < NUM_OPC; i++) begin : g_cmp
        assign hit_vec[i] = (major == OPC_LIST[i*MAJOR_W +: MAJOR_W]);
    end

    // any listed opcode matches
    assign hit = |hit_vec;

endmodule

// File: rtl/cdm_next_mode.sv
// Transition logic: from the mode applying now and the halfword end
// bits, produce the mode for the following instruction and the
// immediate-form indication.
// Assumes: end_hi is the halfword's top bit, end_lo its bit 0.
module cdm_next_mode
    import cdm_pkg::*;
(
    input  cdm_mode_e cur,
    input  logic      end_hi,
    input  logic      end_lo,
    output cdm_mode_e nxt,
    output logic      imm_hit
);

    // per-mode successor and immediate-form decode
    always_comb begin
        nxt     = MODE_STD;
        imm_hit = 1'b0;
        case (cur)
            MODE_STD:  nxt = MODE_STD;
            MODE_C10:  nxt = end_hi ? MODE_C16 : MODE_STD;
            MODE_C16: begin
                if (end_hi) begin
                    nxt     = MODE_C16;
                    imm_hit = end_lo;
                end else begin
                    nxt = end_lo ? MODE_PEND : MODE_STD;
                end
            end
            MODE_PEND: nxt = MODE_C16;
            default:   nxt = MODE_STD;
        endcase
    end

endmodule

// File: rtl/cdm_mode_reg.sv
// Held-mode register. Reset and flush force standard mode; otherwise
// the register loads the successor only on an accepted instruction.
// Assumes: synchronous active-low reset.
module cdm_mode_reg
    import cdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      accept,
    input  cdm_mode_e nxt,
    output cdm_mode_e mode_q
);

    // hold, load on accept, clear on reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            mode_q <= MODE_STD;
        end else if (accept) begin
            mode_q <= nxt;
        end
    end

endmodule

// File: rtl/cdm_mode_fsm.sv
// Top of the compressed decode mode tracker. Reports the mode applying
// to the presented instruction, the immediate-form flag and the mode for
// the following instruction. A listed major opcode seen while standard
// is held turns that one instruction into a 10-bit halfword.
// Assumes: in_major and in_hword belong to the same presented instruction.
module cdm_mode_fsm
    import cdm_pkg::*;
#(
    parameter int HW_W    = 16,
    parameter int MAJOR_W = 6,
    parameter int NUM_OPC = 2,
    parameter logic [NUM_OPC*MAJOR_W-1:0] OPC_LIST = {6'd1, 6'd0}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    input  logic               in_ready,
    input  logic [MAJOR_W-1:0] in_major,
    input  logic [HW_W-1:0]    in_hword,
    output logic [1:0]         cur_mode,
    output logic               imm_form,
    output logic [1:0]         next_mode
);

    localparam int HI_BIT = HW_W - 1;

    cdm_mode_e mode_q;
    cdm_mode_e cur_e;
    cdm_mode_e nxt_e;
    logic      opc_hit;
    logic      imm_hit;
    logic      accept;
    logic      unused_mid;

    // only the end bits steer the mode
    assign unused_mid = ^in_hword[HI_BIT-1:1];

    // handshake completes
    assign accept = in_valid && in_ready;

    cdm_opc_match #(
        .MAJOR_W  (MAJOR_W),
        .NUM_OPC  (NUM_OPC),
        .OPC_LIST (OPC_LIST)
    ) u_match (
        .major (in_major),
        .hit   (opc_hit)
    );

    // standard held plus a listed opcode means a 10-bit halfword now
    assign cur_e = (mode_q == MODE_STD && opc_hit) ? MODE_C10 : mode_q;

    cdm_next_mode u_next (
        .cur     (cur_e),
        .end_hi  (in_hword[HI_BIT]),
        .end_lo  (in_hword[0]),
        .nxt     (nxt_e),
        .imm_hit (imm_hit)
    );

    cdm_mode_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .accept (accept),
        .nxt    (nxt_e),
        .mode_q (mode_q)
    );

    // outputs
    assign cur_mode  = cur_e;
    assign imm_form  = in_valid && imm_hit;
    assign next_mode = flush ? MODE_STD : (accept ? nxt_e : mode_q);

endmodule

// File: rtl/cdm_mode_fsm_chk.sv
// Property checker for the compressed decode mode tracker, bound to the
// top. Observes the held mode and the ports.
module cdm_mode_fsm_chk #(
    parameter int HW_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            accept,
    input logic            in_valid,
    input logic [HW_W-1:0] in_hword,
    input logic [1:0]      mode_q,
    input logic [1:0]      cur_mode,
    input logic            imm_form,
    input logic [1:0]      next_mode
);

    // R1
    flush_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> mode_q == 2'b00);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !flush) |=> $stable(mode_q));

    // R3
    c10_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mode == 2'b01 |-> mode_q == 2'b00);

    // R3
    no_c10_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'b01);

    // R4
    c10_to_c16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flush && cur_mode == 2'b01 && in_hword[HW_W-1]) |=> mode_q == 2'b10);

    // R5
    c10_to_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flush && cur_mode == 2'b01 && !in_hword[HW_W-1]) |=> mode_q == 2'b00);

    // R7
    c16_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flush && cur_mode == 2'b10 && in_hword[HW_W-1]) |=> mode_q == 2'b10);

    // R9
    c16_to_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flush && cur_mode == 2'b10 && !in_hword[HW_W-1] && in_hword[0])
        |=> mode_q == 2'b11);

    // R10
    pend_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flush && mode_q == 2'b11) |=> mode_q == 2'b10);

    // R6
    imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm_form |-> (in_valid && cur_mode == 2'b10 && in_hword[HW_W-1] && in_hword[0]));

    // R11
    next_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> mode_q == $past(next_mode));

endmodule

bind cdm_mode_fsm cdm_mode_fsm_chk #(.HW_W(HW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .accept    (accept),
    .in_valid  (in_valid),
    .in_hword  (in_hword),
    .mode_q    (mode_q),
    .cur_mode  (cur_mode),
    .imm_form  (imm_form),
    .next_mode (next_mode)
);

// File: tb/sim_cdm_mode_fsm.sv
`timescale 1ns/1ps
module sim_cdm_mode_fsm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready = 1'b0;
    logic [5:0]  in_major = 6'd0;
    logic [15:0] in_hword = 16'd0;
    logic [1:0]  cur_mode;
    logic        imm_form;
    logic [1:0]  next_mode;

    int n_checks = 0;
    int n_fail   = 0;
    int m_state  = 0;   // reference held mode: 0 std, 1 c10, 2 c16, 3 pend
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cdm_mode_fsm u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_major(in_major), .in_hword(in_hword),
        .cur_mode(cur_mode), .imm_form(imm_form), .next_mode(next_mode)
    );

    function automatic int exp_cur(int st, int maj);
        if (st == 0 && (maj == 0 || maj == 1)) return 1;
        return st;
    endfunction

    function automatic int exp_succ(int cur, bit hi, bit lo);
        if (cur == 1) return hi ? 2 : 0;
        if (cur == 2) begin
            if (hi) return 2;
            return lo ? 3 : 0;
        end
        if (cur == 3) return 2;
        return 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // apply one cycle of stimulus, check at the falling edge, step the model
    task automatic step(string req, bit v, bit r, bit f, int maj, logic [15:0] hw);
        int c, s, nx, im;
        in_valid = v; in_ready = r; flush = f;
        in_major = maj[5:0]; in_hword = hw;
        @(negedge clk);
        c  = exp_cur(m_state, maj);
        s  = exp_succ(c, hw[15], hw[0]);
        im = (v && c == 2 && hw[15] && hw[0]) ? 1 : 0;
        nx = f ? 0 : ((v && r) ? s : m_state);
        chk(req, "cur_mode", int'(cur_mode), c);
        chk(req, "imm_form", int'(imm_form), im);
        chk(req, "next_mode", int'(next_mode), nx);
        @(posedge clk);
        m_state = nx;
        #1;
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        // R1: reset held with accepted traffic that would leave standard
        in_valid = 1'b1; in_ready = 1'b1; in_major = 6'd0; in_hword = 16'h8000;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_state = 0;
        in_major = 6'd5;
        @(negedge clk);
        chk("R1", "cur_mode after reset", int'(cur_mode), 0);
        @(posedge clk); #1;

        step("R3", 1, 1, 0, 5,  16'hFFFF);   // other opcode stays standard
        step("R3", 1, 1, 0, 0,  16'h8000);   // opcode 0 -> 10-bit; R4 -> 16-bit
        step("R6", 1, 1, 0, 9,  16'h8001);   // immediate form
        step("R7", 1, 1, 0, 9,  16'h8000);   // stay 16-bit
        step("R2", 1, 0, 0, 9,  16'h0000);   // not accepted: hold
        step("R2", 0, 1, 0, 9,  16'h0001);   // not valid: hold
        step("R9", 1, 1, 0, 9,  16'h0001);   // to pending
        step("R10", 1, 1, 0, 0, 16'h0000);   // pending ignores opcode/bits
        step("R8", 1, 1, 0, 3,  16'h0000);   // 16-bit -> standard
        step("R5", 1, 1, 0, 1,  16'h7FFF);   // opcode 1 -> 10-bit -> standard
        step("R4", 1, 1, 0, 0,  16'h8000);   // back to 16-bit
        step("R1", 1, 1, 1, 9,  16'h0001);   // flush beats accept
        step("R1", 1, 1, 0, 7,  16'h0000);   // confirm standard held
        step("R4", 1, 1, 0, 1,  16'hFFFE);
        step("R9", 1, 1, 0, 2,  16'h7FFF);
        step("R10", 1, 0, 0, 1, 16'h0000);   // pending holds without accept
        step("R10", 1, 1, 0, 1, 16'h0001);
        step("R6", 0, 0, 0, 2,  16'h8001);   // R11: imm needs valid

        // R11: long mixed run with flush and reset
        for (int i = 0; i < 2000; i++) begin
            bit v, r, f;
            int maj;
            logic [15:0] hw;
            v   = ($urandom % 4) != 0;
            r   = ($urandom % 3) != 0;
            f   = ($urandom % 40) == 0;
            maj = ($urandom % 2) ? int'($urandom % 2) : int'($urandom % 64);
            hw  = 16'($urandom);
            if (i == 1000) begin
                rst_n = 1'b0;
                @(posedge clk); #1;
                rst_n = 1'b1;
                m_state = 0;
            end
            step("R11", v, r, f, maj, hw);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule